// File: doc/BRIEF.md
# Backup Supply Source Controller

This block picks which supply feeds a battery-backed memory rail. While the main supply stays above the switchover level, the rail comes from the main supply. Once the main supply drops below that level, the block picks a backup cell. The first cell is preferred for as long as it is fitted and above 2.5 V. Otherwise the block uses the second cell. When neither cell can be used, the rail is left unfed. All inputs are synchronous flags produced by analog comparators and detectors outside the block. The outputs are a registered one-hot source select and a registered isolation status bit. The power switches that act on the select are outside the block.

An isolation latch disconnects both cells so that they do not drain while the memory holds nothing worth keeping. Two events set the latch. The first is a battery-inserted event. The second is a timed chip-enable pattern seen during a power-down. For that pattern, chip-enable must be low when the supply crosses the power-fail level. It must then rest at mid level for a run of `MID_CYCLES` clocks. It must be low again when the supply crosses the switchover level. The latch clears as soon as the main supply is back above the power-fail level.

Top module: `bkup_src_ctrl`

## Requirements
- R1: While `below_so` is 0, `src_sel` is MAIN (4'b0001) one clock later.
- R2: In backup (`below_so`=1, not isolated), the select is BAT1 (4'b0010) when `bat1_present` and `bat1_ok` are both 1 and no fallback has occurred during this power-down.
- R3: In backup, once the first cell is unusable in any clock, the select is BAT2 (4'b0100). It stays BAT2 even if the first cell recovers, until `below_so` returns to 0.
- R4: A cell whose present flag is 0 is never selected. With no usable cell, the select is NONE (4'b1000).
- R5: When `bat_insert` is 1 while `below_pf` is 1, `isolated` is 1 on the next clock. From then on the select shows no cell.
- R6: When `below_pf` is 0, `isolated` is 0 on the next clock.
- R7: An isolation request sets `isolated` and drives the select to NONE on the clock after `below_so` rises. The request needs three things. `ce_low` must be 1 on the clock `below_pf` rises. A mid-level run must then be seen. `ce_low` must be 1 on the clock `below_so` rises.
- R8: The mid-level run must be at least `MID_CYCLES` consecutive clocks with `ce_mid`=1. A shorter run does not qualify, and neither does a run broken into shorter pieces.
- R9: If chip-enable is high (`ce_low`=0 and `ce_mid`=0) in any clock between the two crossings, the request is void.
- R10: After reset, `src_sel` is MAIN and `isolated` is 0. `src_sel` always has exactly one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| below_so | input | 1 | Main supply below switchover level |
| below_pf | input | 1 | Main supply below power-fail level |
| bat1_present | input | 1 | First cell fitted |
| bat2_present | input | 1 | Second cell fitted |
| bat1_ok | input | 1 | First cell above 2.5 V |
| bat_insert | input | 1 | Battery-inserted event pulse |
| ce_low | input | 1 | Chip-enable at low level |
| ce_mid | input | 1 | Chip-enable at mid level |
| src_sel | output | 4 | One-hot source: bit0 MAIN, bit1 BAT1, bit2 BAT2, bit3 NONE |
| isolated | output | 1 | Cells latched off |

## Verification
Both outputs are registered. Each responds exactly one clock after the input pattern that causes it, and that includes an isolation request decided on the switchover-crossing clock. The bench drives every input on the falling edge and checks the outputs just after the next rising edge. For a sequence, each check follows the clock that carries its last stimulus. The mid-level window is shrunk to four clocks. Runs of zero to six clocks, a split run and a high glitch then sit on both sides of the bound.

// File: rtl/bkup_src_pkg.sv
package bkup_src_pkg;
  localparam int SRC_W    = 4;
  localparam int SRC_MAIN = 0;
  localparam int SRC_B1   = 1;
  localparam int SRC_B2   = 2;
  localparam int SRC_NONE = 3;

  typedef enum logic [1:0] {
    DET_IDLE  = 2'd0,
    DET_ARMED = 2'd1,
    DET_SPENT = 2'd2
  } det_state_t;

  function automatic logic [SRC_W-1:0] src_onehot(input int idx);
    logic [SRC_W-1:0] v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/bkup_iso_detect.sv
module bkup_iso_detect #(
  parameter int MID_CYCLES = 140
) (
  input  logic clk,
  input  logic rst,
  input  logic below_pf,
  input  logic below_so,
  input  logic ce_low,
  input  logic ce_mid,
  output logic iso_req
);
  import bkup_src_pkg::*;

  localparam int CNT_W = $clog2(MID_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MID_CYCLES);

  det_state_t       st_q;
  logic [CNT_W-1:0] run_q;
  logic             run_ok_q;
  logic             pf_q, so_q;
  logic             pf_rise, so_rise, ce_high;
  logic             run_hits;

  assign pf_rise  = below_pf && !pf_q;
  assign so_rise  = below_so && !so_q;
  assign ce_high  = !ce_low && !ce_mid;
  assign run_hits = (32'(run_q) + 32'd1) >= 32'(MID_CYCLES);

  assign iso_req = so_rise && (st_q == DET_ARMED) && ce_low && run_ok_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pf_q     <= 1'b0;
      so_q     <= 1'b0;
      st_q     <= DET_IDLE;
      run_q    <= '0;
      run_ok_q <= 1'b0;
    end else begin
      pf_q <= below_pf;
      so_q <= below_so;
      if (!below_pf) begin
        st_q     <= DET_IDLE;
        run_q    <= '0;
        run_ok_q <= 1'b0;
      end else if (pf_rise) begin
        st_q     <= ce_low ? DET_ARMED : DET_SPENT;
        run_q    <= '0;
        run_ok_q <= 1'b0;
      end else if (st_q == DET_ARMED) begin
        if (so_rise || ce_high) begin
          st_q <= DET_SPENT;
        end else if (ce_mid) begin
          if (run_q != CNT_MAX) run_q <= run_q + 1'b1;
          if (run_hits) run_ok_q <= 1'b1;
        end else begin
          run_q <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/bkup_iso_latch.sv
module bkup_iso_latch (
  input  logic clk,
  input  logic rst,
  input  logic below_pf,
  input  logic bat_insert,
  input  logic iso_req,
  output logic iso_next,
  output logic iso_q
);
  assign iso_next = below_pf && (iso_q || bat_insert || iso_req);

  always_ff @(posedge clk) begin
    if (rst) iso_q <= 1'b0;
    else     iso_q <= iso_next;
  end
endmodule

// File: rtl/bkup_src_pick.sv
module bkup_src_pick (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           below_so,
  input  logic                           bat1_present,
  input  logic                           bat2_present,
  input  logic                           bat1_ok,
  input  logic                           iso_next,
  output logic [bkup_src_pkg::SRC_W-1:0] sel_q
);
  import bkup_src_pkg::*;

  logic             fell_q;
  logic             b1_usable, use_b1;
  logic [SRC_W-1:0] sel_d;

  assign b1_usable = bat1_present && bat1_ok;
  assign use_b1    = b1_usable && !fell_q;

  always_comb begin
    if (!below_so)         sel_d = src_onehot(SRC_MAIN);
    else if (iso_next)     sel_d = src_onehot(SRC_NONE);
    else if (use_b1)       sel_d = src_onehot(SRC_B1);
    else if (bat2_present) sel_d = src_onehot(SRC_B2);
    else                   sel_d = src_onehot(SRC_NONE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= src_onehot(SRC_MAIN);
      fell_q <= 1'b0;
    end else begin
      sel_q  <= sel_d;
      fell_q <= below_so && (fell_q || !b1_usable);
    end
  end
endmodule

// File: rtl/bkup_src_ctrl.sv
module bkup_src_ctrl #(
  parameter int MID_CYCLES = 140
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       below_so,
  input  logic       below_pf,
  input  logic       bat1_present,
  input  logic       bat2_present,
  input  logic       bat1_ok,
  input  logic       bat_insert,
  input  logic       ce_low,
  input  logic       ce_mid,
  output logic [3:0] src_sel,
  output logic       isolated
);
  logic iso_req, iso_next;

  bkup_iso_detect #(.MID_CYCLES(MID_CYCLES)) u_det (
    .clk(clk), .rst(rst), .below_pf(below_pf), .below_so(below_so),
    .ce_low(ce_low), .ce_mid(ce_mid), .iso_req(iso_req)
  );

  bkup_iso_latch u_lat (
    .clk(clk), .rst(rst), .below_pf(below_pf), .bat_insert(bat_insert),
    .iso_req(iso_req), .iso_next(iso_next), .iso_q(isolated)
  );

  bkup_src_pick u_pick (
    .clk(clk), .rst(rst), .below_so(below_so), .bat1_present(bat1_present),
    .bat2_present(bat2_present), .bat1_ok(bat1_ok), .iso_next(iso_next),
    .sel_q(src_sel)
  );
endmodule

// File: rtl/bkup_src_ctrl_chk.sv
module bkup_src_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       below_so,
  input logic       below_pf,
  input logic       bat1_present,
  input logic       bat2_present,
  input logic       bat_insert,
  input logic       ce_low,
  input logic [3:0] src_sel,
  input logic       isolated
);
  assert_onehot_R10: assert property (@(posedge clk) disable iff (rst)
    $countones(src_sel) == 1);

  assert_main_R1: assert property (@(posedge clk) disable iff (rst)
    !below_so |=> src_sel[0]);

  assert_no_return_R3: assert property (@(posedge clk) disable iff (rst)
    (src_sel[2] && below_so) |=> !src_sel[1]);

  assert_absent1_R4: assert property (@(posedge clk) disable iff (rst)
    !bat1_present |=> !src_sel[1]);

  assert_absent2_R4: assert property (@(posedge clk) disable iff (rst)
    !bat2_present |=> !src_sel[2]);

  assert_insert_R5: assert property (@(posedge clk) disable iff (rst)
    (below_pf && bat_insert) |=> isolated);

  assert_iso_off_R5: assert property (@(posedge clk) disable iff (rst)
    isolated |-> !src_sel[1] && !src_sel[2]);

  assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
    !below_pf |=> !isolated);

  assert_set_cause_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(isolated) |-> ($past(bat_insert) || ($past(below_so) && $past(ce_low))));
endmodule

bind bkup_src_ctrl bkup_src_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .below_so(below_so), .below_pf(below_pf),
  .bat1_present(bat1_present), .bat2_present(bat2_present),
  .bat_insert(bat_insert), .ce_low(ce_low), .src_sel(src_sel),
  .isolated(isolated)
);

// File: tb/tb_bkup_src_ctrl.sv
`timescale 1ns/1ps
module tb_bkup_src_ctrl;
  localparam int MID = 4;
  localparam logic [3:0] S_MAIN = 4'b0001, S_B1 = 4'b0010,
                         S_B2 = 4'b0100, S_NONE = 4'b1000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic below_so = 0, below_pf = 0, bat1_present = 0, bat2_present = 0;
  logic bat1_ok = 0, bat_insert = 0, ce_low = 0, ce_mid = 0;
  logic [3:0] src_sel;
  logic isolated;
  int checks = 0, failures = 0;
  bit timeout = 0;

  always #2.5 clk = ~clk;

  bkup_src_ctrl #(.MID_CYCLES(MID)) dut (
    .clk(clk), .rst(rst), .below_so(below_so), .below_pf(below_pf),
    .bat1_present(bat1_present), .bat2_present(bat2_present),
    .bat1_ok(bat1_ok), .bat_insert(bat_insert), .ce_low(ce_low),
    .ce_mid(ce_mid), .src_sel(src_sel), .isolated(isolated)
  );

  task automatic tick();
    @(posedge clk);
    #1;
    @(negedge clk);
  endtask

  task automatic chk_sel(input logic [3:0] exp, input string req);
    checks++;
    if (src_sel !== exp) begin
      failures++;
      $display("FAIL %s src_sel actual=%b expected=%b", req, src_sel, exp);
    end
  endtask

  task automatic chk_iso(input logic exp, input string req);
    checks++;
    if (isolated !== exp) begin
      failures++;
      $display("FAIL %s isolated actual=%b expected=%b", req, isolated, exp);
    end
  endtask

  task automatic main_ok();
    below_so = 0; below_pf = 0; ce_low = 0; ce_mid = 0; bat_insert = 0;
    tick(); tick();
  endtask

  // mid_a mid clocks, optional low gap, mid_b mid clocks, optional high glitch
  task automatic iso_seq(input int mid_a, input int mid_b, input bit gap,
                         input bit glitch, input bit low_at_pf,
                         input bit low_at_so, input bit exp, input string req);
    bat1_present = 1; bat2_present = 1; bat1_ok = 1;
    main_ok();
    below_pf = 1; ce_low = low_at_pf; ce_mid = !low_at_pf; tick();
    for (int i = 0; i < mid_a; i++) begin ce_low = 0; ce_mid = 1; tick(); end
    if (gap) begin ce_low = 1; ce_mid = 0; tick(); end
    for (int i = 0; i < mid_b; i++) begin ce_low = 0; ce_mid = 1; tick(); end
    if (glitch) begin ce_low = 0; ce_mid = 0; tick(); end
    ce_low = 1; ce_mid = 0; tick();
    ce_low = low_at_so; ce_mid = !low_at_so; below_so = 1; tick();
    chk_iso(exp, req);
    chk_sel(exp ? S_NONE : S_B1, req);
  endtask

  task automatic run_all();
    logic [3:0] e1, e2;
    repeat (3) tick();
    chk_sel(S_MAIN, "R10");
    chk_iso(1'b0, "R10");
    rst = 0;
    tick();
    chk_sel(S_MAIN, "R10");

    // sweep of every cell-flag combination: R1 R2 R3 R4
    for (int c = 0; c < 8; c++) begin
      bat1_present = c[0]; bat2_present = c[1]; bat1_ok = c[2];
      main_ok();
      chk_sel(S_MAIN, "R1");
      below_pf = 1; below_so = 1; tick();
      e1 = (c[0] && c[2]) ? S_B1 : (c[1] ? S_B2 : S_NONE);
      chk_sel(e1, "R2");
      bat1_ok = 0; tick();
      e2 = c[1] ? S_B2 : S_NONE;
      chk_sel(e2, "R4");
      bat1_ok = 1; tick();
      chk_sel(e2, "R3");
      below_so = 0; tick();
      chk_sel(S_MAIN, "R1");
    end

    // isolation window sweep: R7 R8
    for (int n = 0; n <= 6; n++)
      iso_seq(n, 0, 0, 0, 1, 1, n >= MID, (n >= MID) ? "R7" : "R8");
    iso_seq(2, 2, 1, 0, 1, 1, 0, "R8");
    iso_seq(3, 3, 1, 0, 1, 1, 0, "R8");
    iso_seq(2, 4, 1, 0, 1, 1, 1, "R8");
    iso_seq(5, 0, 0, 1, 1, 1, 0, "R9");
    iso_seq(5, 0, 0, 0, 0, 1, 0, "R7");
    iso_seq(5, 0, 0, 0, 1, 0, 0, "R7");

    // isolation persists through return of rail, clears on valid main: R6
    iso_seq(5, 0, 0, 0, 1, 1, 1, "R7");
    below_so = 0; tick();
    chk_sel(S_MAIN, "R1");
    chk_iso(1'b1, "R6");
    below_pf = 0; tick();
    chk_iso(1'b0, "R6");

    // battery inserted event: R5
    bat1_present = 1; bat2_present = 1; bat1_ok = 1;
    main_ok();
    below_pf = 1; below_so = 1; ce_low = 0; tick();
    chk_sel(S_B1, "R2");
    bat_insert = 1; tick();
    bat_insert = 0;
    chk_iso(1'b1, "R5");
    chk_sel(S_NONE, "R5");
    tick();
    chk_sel(S_NONE, "R5");
    main_ok();
    chk_iso(1'b0, "R6");
    chk_sel(S_MAIN, "R1");
  endtask

  initial begin
    @(negedge clk);
    fork
      run_all();
      begin repeat (50000) @(posedge clk); timeout = 1; end
    join_any
    disable fork;
    if (timeout) begin
      failures++;
      $display("FAIL watchdog actual=expired expected=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule